// File: doc/BRIEF.md
# Memory-Fill DMA Channel

This block is one channel of a DMA engine that runs only in memory-initialise mode. It writes a 64-bit pattern over and over across a destination region. Software sets up the channel through a small word-addressed register port. It programs a destination pointer, a byte count, and the two 32-bit halves of the pattern, then sends commands to an activation register. The status field of that same register shows whether the channel is idle, running or paused.

While running, the channel presents one 64-bit write beat at a time on a valid/ready handshake. Each beat's address is 8 bytes above the one before. The channel flags the final beat of every burst. The burst length comes from a code in the configuration register. Whether a command takes effect depends on the current state. A command that does not fit the current state changes nothing.

Top module: `mfill_chan`

## Requirements
- R1: After reset the status reads idle (0), `wr_valid` is low, both burst-limit codes in the configuration register (address 0; destination code in bits [2:0], source code in bits [6:4]) read 4, and the mode field in bits [9:8] reads 2, meaning memory-initialise.
- R2: Register addresses are: 1 for the destination pointer, 2 for the byte count, 3 for the low pattern word and 4 for the high pattern word. Writing bit 0 (start) of register 5 while idle, with a legal count, moves the status to active (1). The channel then presents count/8 beats. Addresses start at the pointer and rise by 8 for each beat. The data on every beat is {high word, low word}. The low 3 bits of the count are ignored.
- R3: The status returns to idle once the last beat of the region has been accepted.
- R4: A start with a count below `BLK_MIN` or above `BLK_MAX` is ignored. The status stays idle and no beat is presented.
- R5: `wr_last` is high on the final beat of each burst. For a code c of 1 to 7, a burst holds 2^(c-1) beats. A code of 0 gives single-beat bursts. The final beat of the region also sets `wr_last`. The burst count restarts after a restart command.
- R6: While `wr_valid` is high and `wr_ready` is low, the channel keeps the beat and its address unchanged until the beat is accepted or the channel is paused or stopped.
- R7: Pause (bit 2 of register 5) while active moves the status to paused (2). While paused no beat is presented, and the address and remaining count are held. Restart (bit 3) from paused resumes at the held address and completes the remaining beats.
- R8: Stop (bit 1) while active returns the status to idle and drops the remaining beats. Stop while idle is accepted but changes nothing.
- R9: Commands that do not fit the current state are ignored: pause or restart while idle, start or restart while active, and stop while paused. In the same write, stop takes priority over pause, and restart takes priority over start.
- R10: Start while paused, with a legal count, begins a fresh fill from the currently programmed pointer and count.
- R11: Writes to the configuration register are ignored while the status is active. Writes never change the mode field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| wr_valid | output | 1 | Write beat valid |
| wr_ready | input | 1 | Write beat accepted |
| wr_addr | output | AW | Byte address of the beat |
| wr_data | output | 64 | Pattern data of the beat |
| wr_last | output | 1 | Final beat of a burst |

## Verification
The bench builds the channel with `BLK_MIN` = 16 and `BLK_MAX` = 256, so a legal region is 2 to 32 beats long. With counts that small, a fill can cover every burst code, run into both count limits, and land on a partial final burst within a few hundred cycles. Address width stays at 32. A pseudo-random ready pattern puts stalls on burst edges and across pause and restart.

// File: rtl/mfill_chan.sv
module mfill_chan #(
  parameter int AW = 32,
  parameter int BLK_MIN = 64,
  parameter int BLK_MAX = 1 << 20,
  parameter logic [2:0] BURST_RST = 3'd4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [63:0]   wr_data,
  output logic          wr_last
);
  localparam int CW = $clog2(BLK_MAX / 8 + 1);
  localparam logic [1:0] ST_IDLE = 2'd0, ST_RUN = 2'd1, ST_HOLD = 2'd2;
  localparam logic [1:0] MODE_FILL = 2'd2;

  logic [1:0]    st_q;
  logic [2:0]    dcode_q, scode_q;
  logic [AW-1:0] dst_q, cur_q;
  logic [31:0]   blk_q, pat_lo_q, pat_hi_q;
  logic [CW-1:0] remain_q;
  logic [6:0]    bcnt_q, blim;

  wire act_wr  = reg_wr && reg_addr == 3'd5;
  wire c_start = act_wr && reg_wdata[0];
  wire c_stop  = act_wr && reg_wdata[1];
  wire c_pause = act_wr && reg_wdata[2];
  wire c_rst   = act_wr && reg_wdata[3];
  wire size_ok = blk_q >= 32'(BLK_MIN) && blk_q <= 32'(BLK_MAX);
  wire fire    = wr_valid && wr_ready;

  assign blim     = (dcode_q == 3'd0) ? 7'd0 : (7'd1 << (dcode_q - 3'd1)) - 7'd1;
  assign wr_valid = st_q == ST_RUN;
  assign wr_addr  = cur_q;
  assign wr_data  = {pat_hi_q, pat_lo_q};
  assign wr_last  = bcnt_q == blim || remain_q == CW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcode_q  <= BURST_RST;
      scode_q  <= BURST_RST;
      dst_q    <= '0;
      blk_q    <= '0;
      pat_lo_q <= '0;
      pat_hi_q <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        3'd0: if (st_q != ST_RUN) begin
                dcode_q <= reg_wdata[2:0];
                scode_q <= reg_wdata[6:4];
              end
        3'd1: dst_q    <= reg_wdata[AW-1:0];
        3'd2: blk_q    <= reg_wdata;
        3'd3: pat_lo_q <= reg_wdata;
        3'd4: pat_hi_q <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      cur_q    <= '0;
      remain_q <= '0;
      bcnt_q   <= '0;
    end else begin
      if (fire) begin
        cur_q    <= cur_q + AW'(8);
        remain_q <= remain_q - CW'(1);
        bcnt_q   <= wr_last ? 7'd0 : bcnt_q + 7'd1;
      end
      case (st_q)
        ST_IDLE: if (c_start && size_ok) begin
          st_q     <= ST_RUN;
          cur_q    <= dst_q;
          remain_q <= blk_q[CW+2:3];
          bcnt_q   <= '0;
        end
        ST_RUN: begin
          if (fire && remain_q == CW'(1)) st_q <= ST_IDLE;
          else if (c_stop)                st_q <= ST_IDLE;
          else if (c_pause)               st_q <= ST_HOLD;
        end
        ST_HOLD: begin
          if (c_rst) begin
            st_q   <= ST_RUN;
            bcnt_q <= '0;
          end else if (c_start && size_ok) begin
            st_q     <= ST_RUN;
            cur_q    <= dst_q;
            remain_q <= blk_q[CW+2:3];
            bcnt_q   <= '0;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {22'd0, MODE_FILL, 1'b0, scode_q, 1'b0, dcode_q};
      3'd1:    reg_rdata = 32'(dst_q);
      3'd2:    reg_rdata = blk_q;
      3'd3:    reg_rdata = pat_lo_q;
      3'd4:    reg_rdata = pat_hi_q;
      3'd5:    reg_rdata = {26'd0, st_q, 4'd0};
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/mfill_chan_chk.sv
module mfill_chan_chk #(
  parameter int AW = 32,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    st,
  input logic [CW-1:0] remain,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [AW-1:0] wr_addr,
  input logic          act_wr,
  input logic [3:0]    cmd,
  input logic          size_ok
);
  wire fire = wr_valid && wr_ready;
  wire brk  = act_wr && (cmd[1] || cmd[2]);

  p_state_legal_r2: assert property (@(posedge clk) disable iff (!rst_n) st != 2'd3);
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fire && remain != CW'(1) && !brk |=> wr_addr == $past(wr_addr) + AW'(8));
  p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fire && remain == CW'(1) |=> st == 2'd0);
  p_bad_size_r4: assert property (@(posedge clk) disable iff (!rst_n)
    st == 2'd0 && act_wr && cmd[0] && !size_ok |=> st == 2'd0 && !wr_valid);
  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready && !brk |=> wr_valid && $stable(wr_addr));
  p_pause_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    st == 2'd2 && !(act_wr && (cmd[0] || cmd[3])) |=> st == 2'd2 && $stable(wr_addr) && $stable(remain));
  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    st == 2'd2 && act_wr && cmd[3] |=> st == 2'd1 && $stable(wr_addr));
  p_stop_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    st == 2'd0 && act_wr && cmd == 4'b0010 |=> st == 2'd0);
endmodule

bind mfill_chan mfill_chan_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .st(st_q), .remain(remain_q),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
  .act_wr(act_wr), .cmd(reg_wdata[3:0]), .size_ok(size_ok)
);

// File: tb/test_mfill_chan.sv
module test_mfill_chan;
  logic clk = 0, rst_n = 0, reg_wr = 0, wr_ready = 1;
  logic [2:0] reg_addr = 3'd5;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic wr_valid, wr_last;
  logic [31:0] wr_addr;
  logic [63:0] wr_data;

  always #2.5 clk = ~clk;

  mfill_chan #(.AW(32), .BLK_MIN(16), .BLK_MAX(256)) i_mfill_chan (.*);

  int n_chk = 0, n_bad = 0;
  int beats = 0, exp_left = 0, inb = 0, exp_blen = 8;
  logic [31:0] exp_addr = '0, st_addr = '0;
  logic [63:0] exp_pat = '0;
  bit stall_en = 0, was_stall = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    wr_ready <= stall_en ? lfsr[0] : 1'b1;
  end

  always @(negedge clk) begin
    #1;
    if (rst_n && was_stall && wr_valid)
      chk(wr_addr == st_addr, "R6", "stalled address", wr_addr, st_addr);
    if (rst_n && wr_valid && wr_ready) begin
      automatic bit el = (inb == exp_blen - 1) || (exp_left == 1);
      beats++;
      chk(wr_addr == exp_addr, "R2", "beat address", wr_addr, exp_addr);
      chk(wr_data == exp_pat, "R2", "beat data", wr_data, exp_pat);
      chk(wr_last == el, "R5", "burst end flag", wr_last, el);
      exp_addr += 8;
      exp_left--;
      inb = el ? 0 : inb + 1;
    end
    was_stall = wr_valid && !wr_ready;
    st_addr = wr_addr;
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0; reg_addr = 3'd5; reg_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic status(output logic [1:0] s);
    logic [31:0] v;
    rd(3'd5, v);
    s = v[5:4];
  endtask

  task automatic wait_idle();
    logic [1:0] s;
    for (int i = 0; i < 600; i++) begin
      status(s);
      if (s == 2'd0) break;
    end
  endtask

  task automatic arm(input logic [31:0] d, input int sz, input int code, input logic [63:0] p);
    exp_addr = d; exp_left = sz / 8; inb = 0; beats = 0; exp_pat = p;
    exp_blen = (code == 0) ? 1 : 1 << (code - 1);
  endtask

  task automatic setup(input logic [31:0] d, input int sz, input int code, input logic [63:0] p);
    wr(3'd0, 32'(code)); wr(3'd1, d); wr(3'd2, 32'(sz));
    wr(3'd3, p[31:0]); wr(3'd4, p[63:32]);
    arm(d, sz, code, p);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // {dst, size, burst code, stall}
  localparam logic [51:0] VEC [6] = '{
    {32'h0000_1000, 16'd64,  3'd4, 1'b0},
    {32'h0000_2000, 16'd256, 3'd4, 1'b1},
    {32'h0000_3008, 16'd72,  3'd2, 1'b1},
    {32'h0000_4000, 16'd16,  3'd0, 1'b0},
    {32'h0000_5000, 16'd40,  3'd7, 1'b1},
    {32'h0000_0000, 16'd24,  3'd1, 1'b0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "R3", "watchdog, run completion", 0, 1);
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [1:0] s;
    int b0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    status(s);
    chk(s == 2'd0, "R1", "reset status", s, 0);
    chk(!wr_valid, "R1", "reset wr_valid", wr_valid, 0);
    rd(3'd0, v);
    chk(v[2:0] == 3'd4, "R1", "reset dst burst code", v[2:0], 4);
    chk(v[6:4] == 3'd4, "R1", "reset src burst code", v[6:4], 4);
    chk(v[9:8] == 2'd2, "R1", "reset mode field", v[9:8], 2);

    wr(3'd0, 32'h0000_0033);
    rd(3'd0, v);
    chk(v[9:8] == 2'd2, "R11", "mode field after write", v[9:8], 2);
    chk(v[2:0] == 3'd3, "R11", "idle config write", v[2:0], 3);

    for (int k = 0; k < 6; k++) begin
      automatic logic [51:0] e = VEC[k];
      automatic logic [63:0] p = {32'hA500_0000 | 32'(k), 32'h3C3C_0000 ^ 32'(k * 7)};
      stall_en = e[0];
      setup(e[51:20], int'(e[19:4]), int'(e[3:1]), p);
      wr(3'd5, 32'h1);
      status(s);
      chk(s == 2'd1, "R2", "status after start", s, 1);
      wait_idle();
      chk(beats == int'(e[19:4]) / 8, "R2", "beat count", beats, e[19:4] / 8);
      status(s);
      chk(s == 2'd0, "R3", "status after fill", s, 0);
    end
    stall_en = 0;

    setup(32'h100, 8, 4, 64'h1);
    wr(3'd5, 32'h1);
    repeat (4) @(negedge clk);
    status(s);
    chk(s == 2'd0 && beats == 0, "R4", "count below min", {s, 8'(beats)}, 0);
    wr(3'd2, 32'd264);
    wr(3'd5, 32'h1);
    repeat (4) @(negedge clk);
    status(s);
    chk(s == 2'd0 && beats == 0, "R4", "count above max", {s, 8'(beats)}, 0);

    wr(3'd2, 32'd64);
    wr(3'd5, 32'h2);
    status(s);
    chk(s == 2'd0 && beats == 0, "R8", "stop while idle", {s, 8'(beats)}, 0);
    wr(3'd5, 32'h4);
    wr(3'd5, 32'h8);
    status(s);
    chk(s == 2'd0 && beats == 0, "R9", "pause/restart while idle", {s, 8'(beats)}, 0);

    stall_en = 1;
    setup(32'h8000, 256, 4, 64'h0123_4567_89AB_CDEF);
    wr(3'd5, 32'h1);
    repeat (5) @(negedge clk);
    wr(3'd5, 32'h4);
    status(s);
    chk(s == 2'd2, "R7", "status after pause", s, 2);
    b0 = beats;
    repeat (10) @(negedge clk);
    chk(beats == b0, "R7", "no beats while paused", beats, b0);
    chk(!wr_valid, "R7", "wr_valid while paused", wr_valid, 0);
    wr(3'd5, 32'h2);
    status(s);
    chk(s == 2'd2, "R9", "stop while paused", s, 2);
    inb = 0;
    wr(3'd5, 32'h8);
    wr(3'd5, 32'h1);
    wr(3'd5, 32'h8);
    wr(3'd0, 32'h1);
    wait_idle();
    chk(beats == 32, "R7", "beats after resume", beats, 32);
    chk(exp_left == 0, "R9", "start/restart ignored while active", exp_left, 0);
    rd(3'd0, v);
    chk(v[2:0] == 3'd4, "R11", "config write while active", v[2:0], 4);

    stall_en = 0;
    setup(32'h9000, 256, 4, 64'h5555_AAAA_5555_AAAA);
    wr(3'd5, 32'h1);
    repeat (4) @(negedge clk);
    wr(3'd5, 32'h2);
    status(s);
    chk(s == 2'd0, "R8", "status after stop", s, 0);
    b0 = beats;
    repeat (10) @(negedge clk);
    chk(beats == b0 && b0 < 32, "R8", "remainder dropped", beats, b0);

    setup(32'hA000, 128, 3, 64'hFEED_F00D_0BAD_CAFE);
    wr(3'd5, 32'h1);
    repeat (3) @(negedge clk);
    wr(3'd5, 32'h4);
    status(s);
    chk(s == 2'd2, "R10", "paused before new start", s, 2);
    wr(3'd1, 32'hB000);
    wr(3'd2, 32'd64);
    arm(32'hB000, 64, 3, 64'hFEED_F00D_0BAD_CAFE);
    wr(3'd5, 32'h1);
    wait_idle();
    chk(beats == 8, "R10", "fresh fill from paused", beats, 8);
    status(s);
    chk(s == 2'd0, "R10", "idle after fresh fill", s, 0);

    summary();
    $finish;
  end
endmodule